// File: doc/BRIEF.md
# Frequency Counter Gate Timebase

This block forms the counting window of a direct-count frequency meter. A reference tick nominally at 100 Hz passes through a chain of decade dividers. The range select picks one divider tap. A divide-by-two toggle stage turns that tap into a gate that is high for exactly one selected period: 10, 100 or 1000 reference ticks, which is 0.1 s, 1 s or 10 s at 100 Hz. While the gate is high, a four-digit BCD counter counts the rising edges of an asynchronous input signal. Before the counter sees the signal, it passes through a two-stage synchronizer and an edge detector.

The counter is cleared by a one-cycle pulse taken from the rising edge of the gate. A display register takes the final count on the falling edge of the gate, so the shown value stays steady while the next window runs. A saturating overflow flag marks a window whose count would pass the largest value the digits can hold. The decimal point follows the range, so the same digits read as 99.99 kHz, 9.999 kHz or 999.9 Hz at full scale. Range code 0 parks the gate, and any change of range restarts the timebase from zero.

Top module: `freq_gate_timebase`

## Requirements
- R1: After reset, gate, count_bcd, count_ovf, disp_bcd, disp_ovf and dp_sel are all zero.
- R2: For range r in 1..3, the gate toggles on every 10^r-th reference tick counted from the last restart. Each high phase therefore lasts exactly 10^r reference ticks, followed by a low phase of the same length.
- R3: Range code 0 holds the gate low. A cycle in which range_sel differs from the previous cycle's value clears the divider chain and drives the gate low at the next clock edge.
- R4: Each rising edge of sig_in reaches the counter two clocks after it is sampled, through the synchronizer. It adds one to the count only if the gate is high in that cycle. Edges arriving while the gate is low leave count_bcd unchanged.
- R5: In the first cycle after the gate rises, the count and count_ovf are cleared. If an input edge is due in that same cycle, the count becomes 1 instead of 0.
- R6: In the first cycle after the gate falls, disp_bcd and disp_ovf take the final count and overflow flag of the window. At all other times they hold their value.
- R7: A counted edge at count 9999 leaves the count at 9999 and sets count_ovf. count_ovf stays set until the next clear.
- R8: dp_sel is one-hot and marks the digit with the decimal point to its right, using the registered range: range 1 gives 4'b0100, range 2 gives 4'b1000, range 3 gives 4'b0010, and range 0 gives 4'b0000.
- R9: count_bcd and disp_bcd hold digit k in bits [4k+3:4k], where digit 0 is the least significant. Each digit is always in the range 0..9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference period (100 Hz nominal) |
| sig_in | input | 1 | Asynchronous signal to be measured |
| range_sel | input | 2 | Range code: 0 parked, 1/2/3 select 10/100/1000-tick gate |
| gate | output | 1 | Counting window |
| count_bcd | output | 16 | Running BCD count of the current window |
| count_ovf | output | 1 | Overflow in the current window |
| disp_bcd | output | 16 | Count latched at the end of the last window |
| disp_ovf | output | 1 | Overflow latched with disp_bcd |
| dp_sel | output | 4 | One-hot decimal-point digit select |

## Verification
The delicate coincidence is between the start-of-window clear and an input edge that emerges from the synchronizer in that same cycle. The clear must win over the old count, but the edge must still be counted as the first event of the new window. The bench drives the signal toggling on every clock across many gate openings so that these coincidences occur repeatedly. A behavioural model, kept as a history queue and plain integers, predicts the count of 1 for each coincidence and tallies how many were hit. The same per-clock comparison also judges the other pairing: the display latch on the gate's falling edge against the last count of the window.

// File: rtl/fgt_pkg.sv
// Shared constants and types for the frequency counter gate timebase.
// Assumes decimal digits held in four-bit BCD fields.
package fgt_pkg;

    localparam int BCD_W   = 4;
    localparam int BCD_MAX = 9;

    typedef logic [BCD_W-1:0] bcd_digit_t;

    // True when a BCD digit is at its top value
    function automatic logic bcd_at_top(input bcd_digit_t d);
        return d == bcd_digit_t'(BCD_MAX);
    endfunction

    // Next value of a BCD digit, wrapping 9 -> 0
    function automatic bcd_digit_t bcd_next(input bcd_digit_t d);
        return bcd_at_top(d) ? '0 : d + bcd_digit_t'(1);
    endfunction

endpackage

// File: rtl/fgt_div_chain.sv
// Chain of modulo-BASE dividers driven by a single-cycle input tick.
// tap_o[k] pulses in the cycle when stages 0..k all wrap together, i.e.
// once every BASE^(k+1) input ticks. restart zeroes every stage.
// Assumes tick_in is a single-cycle pulse synchronous to clk.
module fgt_div_chain #(
    parameter int N_STAGES = 3,
    parameter int BASE     = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                tick_in,
    output logic [N_STAGES-1:0] tap_o
);

    localparam int CW = (BASE > 1) ? $clog2(BASE) : 1;
    localparam logic [CW-1:0] TOP = CW'(BASE - 1);

    logic [N_STAGES:0] carry;

    assign carry[0] = tick_in;

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        logic [CW-1:0] cnt;

        // Advance this stage on each carry from below, wrapping at BASE
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (restart) begin
                cnt <= '0;
            end else if (carry[g]) begin
                cnt <= (cnt == TOP) ? '0 : cnt + CW'(1);
            end
        end

        // Pass a carry upward when this stage wraps
        assign carry[g+1] = carry[g] && (cnt == TOP);
    end

    assign tap_o = carry[N_STAGES:1];

endmodule

// File: rtl/fgt_gate_ctrl.sv
// Gate former: registers the range code, restarts the timebase on any
// range change, toggles the gate on the selected divider tap, and derives
// single-cycle pulses for the gate's rising and falling edges.
// Assumes tap_i[k] is the tap for range code k+1; code 0 parks the gate.
module fgt_gate_ctrl #(
    parameter int N_STAGES = 3,
    parameter int RW       = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RW-1:0]       range_sel,
    input  logic [N_STAGES-1:0] tap_i,
    output logic [RW-1:0]       range_q,
    output logic                restart,
    output logic                gate,
    output logic                rise_p,
    output logic                fall_p
);

    logic sel_tick;
    logic gate_d;

    // Hold the range code seen last cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_q <= '0;
        end else begin
            range_q <= range_sel;
        end
    end

    // Any change of range restarts the dividers and the gate
    assign restart = (range_sel != range_q);

    // Pick the divider tap that belongs to the registered range
    always_comb begin
        sel_tick = 1'b0;
        for (int k = 0; k < N_STAGES; k++) begin
            if (range_q == RW'(k + 1)) begin
                sel_tick = tap_i[k];
            end
        end
    end

    // Divide-by-two toggle stage producing the gate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate <= 1'b0;
        end else if (restart || (range_q == '0)) begin
            gate <= 1'b0;
        end else if (sel_tick) begin
            gate <= ~gate;
        end
    end

    // Delayed gate for edge pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_d <= 1'b0;
        end else begin
            gate_d <= gate;
        end
    end

    assign rise_p = gate & ~gate_d;
    assign fall_p = ~gate & gate_d;

endmodule

// File: rtl/fgt_sync_edge.sv
// Brings an asynchronous signal into the clk domain through STAGES flops
// and flags each rising edge with a single-cycle pulse.
// Assumes STAGES >= 2 for metastability settling.
module fgt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES:0] sh;

    // Shift the input through the synchronizer and one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], async_i};
        end
    end

    assign rise_o = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/fgt_bcd_count.sv
// Multi-digit BCD event counter. clr starts a new window and counts a
// coincident event as the first one; at all-nines a further event holds
// the value and sets the overflow flag.
// Assumes clr and inc are synchronous single-cycle qualifiers.
module fgt_bcd_count
    import fgt_pkg::*;
#(
    parameter int N_DIGITS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      inc,
    output logic [N_DIGITS*BCD_W-1:0] count_o,
    output logic                      ovf_o
);

    bcd_digit_t        dig [N_DIGITS];
    logic [N_DIGITS:0] lower_top;
    logic              full;

    assign lower_top[0] = 1'b1;
    assign full         = lower_top[N_DIGITS];

    for (genvar g = 0; g < N_DIGITS; g++) begin : g_digit
        localparam bit IS_LSD = (g == 0);

        // Digit g may step only when every lower digit is at 9
        assign lower_top[g+1] = lower_top[g] && bcd_at_top(dig[g]);

        // Clear, step or hold this digit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dig[g] <= '0;
            end else if (clr) begin
                dig[g] <= (IS_LSD && inc) ? bcd_digit_t'(1) : '0;
            end else if (inc && !full && lower_top[g]) begin
                dig[g] <= bcd_next(dig[g]);
            end
        end

        assign count_o[g*BCD_W +: BCD_W] = dig[g];
    end

    // Sticky overflow within one window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_o <= 1'b0;
        end else if (clr) begin
            ovf_o <= 1'b0;
        end else if (inc && full) begin
            ovf_o <= 1'b1;
        end
    end

endmodule

// File: rtl/freq_gate_timebase.sv
// Top of the frequency counter gate timebase. Divides the reference tick
// through a decade chain, forms a gate one selected period long, counts
// synchronized input edges inside it, latches the result when the gate
// closes and points the decimal point for the range.
// Assumes ref_tick is a single-cycle pulse and sig_in is asynchronous.
module freq_gate_timebase #(
    parameter int N_DIGITS    = 4,
    parameter int N_DIV       = 3,
    parameter int DIV_BASE    = 10,
    parameter int SYNC_STAGES = 2,
    parameter int RW          = $clog2(N_DIV + 1),
    parameter int CNT_W       = N_DIGITS * fgt_pkg::BCD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             sig_in,
    input  logic [RW-1:0]    range_sel,
    output logic             gate,
    output logic [CNT_W-1:0] count_bcd,
    output logic             count_ovf,
    output logic [CNT_W-1:0] disp_bcd,
    output logic             disp_ovf,
    output logic [N_DIGITS-1:0] dp_sel
);

    // Digit that carries the point for each range code
    localparam int DP_R1 = N_DIGITS - 2;
    localparam int DP_R2 = N_DIGITS - 1;
    localparam int DP_R3 = N_DIGITS - 3;

    logic [N_DIV-1:0] taps;
    logic [RW-1:0]    range_q;
    logic             restart;
    logic             rise_p;
    logic             fall_p;
    logic             sig_rise;
    logic             count_inc;

    fgt_div_chain #(
        .N_STAGES (N_DIV),
        .BASE     (DIV_BASE)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick_in (ref_tick),
        .tap_o   (taps)
    );

    fgt_gate_ctrl #(
        .N_STAGES (N_DIV),
        .RW       (RW)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .range_sel (range_sel),
        .tap_i     (taps),
        .range_q   (range_q),
        .restart   (restart),
        .gate      (gate),
        .rise_p    (rise_p),
        .fall_p    (fall_p)
    );

    fgt_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sig_in),
        .rise_o  (sig_rise)
    );

    assign count_inc = gate & sig_rise;

    fgt_bcd_count #(
        .N_DIGITS (N_DIGITS)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rise_p),
        .inc     (count_inc),
        .count_o (count_bcd),
        .ovf_o   (count_ovf)
    );

    // Capture the finished window when the gate closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_bcd <= '0;
            disp_ovf <= 1'b0;
        end else if (fall_p) begin
            disp_bcd <= count_bcd;
            disp_ovf <= count_ovf;
        end
    end

    // Place the decimal point from the registered range
    always_comb begin
        dp_sel = '0;
        case (int'(range_q))
            1:       dp_sel[DP_R1] = 1'b1;
            2:       dp_sel[DP_R2] = 1'b1;
            3:       dp_sel[DP_R3] = 1'b1;
            default: dp_sel = '0;
        endcase
    end

endmodule

// File: rtl/fgt_checks.sv
// Property checker for freq_gate_timebase, attached with bind below.
// Assumes the default BCD digit layout of the top module.
module fgt_checks #(
    parameter int N_DIGITS = 4,
    parameter int RW       = 2,
    parameter int CNT_W    = N_DIGITS * 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [RW-1:0]       range_sel,
    input logic                gate,
    input logic [CNT_W-1:0]    count_bcd,
    input logic                count_ovf,
    input logic [CNT_W-1:0]    disp_bcd,
    input logic [N_DIGITS-1:0] dp_sel
);

    localparam logic [CNT_W-1:0] ALL_NINES = {N_DIGITS{4'h9}};

    // R3
    parked_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (range_sel == '0) |=> !gate);

    // R4
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> $stable(count_bcd));

    // R5
    window_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |=> (count_bcd <= CNT_W'(1)) && !count_ovf);

    // R6
    disp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |=> (disp_bcd == $past(count_bcd)));

    // R6
    disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(gate) |=> $stable(disp_bcd));

    // R7
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_ovf |-> (count_bcd == ALL_NINES));

    // R8
    dp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dp_sel));

    for (genvar g = 0; g < N_DIGITS; g++) begin : g_dig
        // R9
        digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (count_bcd[g*4 +: 4] <= 4'd9) && (disp_bcd[g*4 +: 4] <= 4'd9));
    end

endmodule

bind freq_gate_timebase fgt_checks #(
    .N_DIGITS (N_DIGITS),
    .RW       (RW),
    .CNT_W    (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .range_sel (range_sel),
    .gate      (gate),
    .count_bcd (count_bcd),
    .count_ovf (count_ovf),
    .disp_bcd  (disp_bcd),
    .dp_sel    (dp_sel)
);

// File: tb/sim_freq_gate_timebase.sv
// Bench for freq_gate_timebase: behavioural per-clock model plus directed checks.
module sim_freq_gate_timebase;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        sig_in = 1'b0;
    logic [1:0]  range_sel = 2'd0;
    logic        gate;
    logic [15:0] count_bcd;
    logic        count_ovf;
    logic [15:0] disp_bcd;
    logic        disp_ovf;
    logic [3:0]  dp_sel;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit cmp_on = 0;

    // stimulus control
    int tick_gap = 1;
    int tick_ph = 0;
    int sig_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    int slow_ph = 0;

    // model state
    int m_tc, m_cnt, m_disp, m_rq;
    bit m_gate, m_gprev, m_ovf, m_dovf;
    int hist[$];
    int collisions = 0;

    // gate length measurement
    int hi_run = 0;
    int last_hi = 0;

    always #(CLK_NS/2) clk = ~clk;

    freq_gate_timebase u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .sig_in    (sig_in),
        .range_sel (range_sel),
        .gate      (gate),
        .count_bcd (count_bcd),
        .count_ovf (count_ovf),
        .disp_bcd  (disp_bcd),
        .disp_ovf  (disp_ovf),
        .dp_sel    (dp_sel)
    );

    function automatic int bcd2int(input logic [15:0] v);
        int r = 0;
        for (int k = 3; k >= 0; k--) r = r * 10 + int'(v[k*4 +: 4]);
        return r;
    endfunction

    function automatic bit digits_ok(input logic [15:0] v);
        for (int k = 0; k < 4; k++) if (v[k*4 +: 4] > 4'd9) return 0;
        return 1;
    endfunction

    function automatic logic [3:0] dp_expect(input int r);
        case (r)
            1: return 4'b0100;
            2: return 4'b1000;
            3: return 4'b0010;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // drive reference tick and input signal away from the active edge
    always @(negedge clk) begin
        ref_tick <= (tick_ph == tick_gap - 1);
        tick_ph  <= (tick_ph >= tick_gap - 1) ? 0 : tick_ph + 1;
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        slow_ph  <= (slow_ph == 4) ? 0 : slow_ph + 1;
        case (sig_mode)
            1: sig_in <= ~sig_in;
            2: sig_in <= lfsr[0];
            3: if (slow_ph == 4) sig_in <= ~sig_in;
            default: sig_in <= sig_in;
        endcase
    end

    // behavioural reference model, advanced on every clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tc = 0; m_cnt = 0; m_disp = 0; m_rq = 0;
            m_gate = 0; m_gprev = 0; m_ovf = 0; m_dovf = 0;
            hist = '{0, 0, 0};
        end else begin
            bit chg, clr, fall, edg, ng;
            int p;
            chg  = (int'(range_sel) != m_rq);
            clr  = m_gate && !m_gprev;
            fall = !m_gate && m_gprev;
            edg  = (hist[1] == 1) && (hist[2] == 0);
            if (fall) begin
                m_disp = m_cnt;
                m_dovf = m_ovf;
            end
            if (clr) begin
                m_cnt = edg ? 1 : 0;
                m_ovf = 0;
                if (edg) collisions++;
            end else if (m_gate && edg) begin
                if (m_cnt == 9999) m_ovf = 1;
                else m_cnt++;
            end
            ng = m_gate;
            if (chg || range_sel == 2'd0) ng = 0;
            else if (ref_tick) begin
                p = 10 ** int'(range_sel);
                if (((m_tc + 1) % p) == 0) ng = !m_gate;
            end
            if (chg) m_tc = 0;
            else if (ref_tick) m_tc = (m_tc + 1) % 1000;
            m_gprev = m_gate;
            m_gate  = ng;
            m_rq    = int'(range_sel);
            hist.push_front(int'(sig_in));
            void'(hist.pop_back());
        end
    end

    // compare outputs with the model on every clock, mid-cycle
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R2", "gate", int'(gate), int'(m_gate));
            check("R4", "count", bcd2int(count_bcd), m_cnt);
            check("R7", "count_ovf", int'(count_ovf), int'(m_ovf));
            check("R6", "disp", bcd2int(disp_bcd), m_disp);
            check("R6", "disp_ovf", int'(disp_ovf), int'(m_dovf));
            check("R8", "dp_sel", int'(dp_sel), int'(dp_expect(m_rq)));
            check("R9", "digits", int'(digits_ok(count_bcd) && digits_ok(disp_bcd)), 1);
        end
        if (gate) hi_run++;
        else begin
            if (hi_run != 0) last_hi = hi_run;
            hi_run = 0;
        end
    end

    initial begin
        int saved;
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1", "gate", int'(gate), 0);
        check("R1", "count", int'(count_bcd), 0);
        check("R1", "disp", int'(disp_bcd), 0);
        check("R1", "ovf", int'(count_ovf | disp_ovf), 0);
        check("R1", "dp_sel", int'(dp_sel), 0);
        rst_n = 1'b1;
        cmp_on = 1;

        // range 1, tick every 3 cycles, toggling input
        tick_gap = 3; sig_mode = 1; range_sel = 2'd1;
        repeat (300) @(negedge clk);
        check("R2", "range1 gate high cycles", last_hi, 30);
        sig_mode = 2;
        repeat (300) @(negedge clk);

        // range 2, tick every cycle, slow input
        tick_gap = 1; sig_mode = 3; range_sel = 2'd2;
        repeat (500) @(negedge clk);
        check("R2", "range2 gate high cycles", last_hi, 100);

        // range 0: gate parked, input edges ignored
        range_sel = 2'd0; sig_mode = 1;
        repeat (10) @(negedge clk);
        saved = bcd2int(count_bcd);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (gate) check("R3", "parked gate", int'(gate), 0);
        end
        check("R3", "parked gate end", int'(gate), 0);
        check("R4", "count with gate low", bcd2int(count_bcd), saved);

        // range change while gate is open restarts the timebase
        range_sel = 2'd1; tick_gap = 1;
        for (int i = 0; i < 100 && !gate; i++) @(negedge clk);
        check("R2", "gate opened", int'(gate), 1);
        range_sel = 2'd2;
        @(negedge clk);
        check("R3", "gate low after range change", int'(gate), 0);

        // R5 coincidence of clear and input edge must have occurred
        check("R5", "clear/edge coincidences seen", int'(collisions > 0), 1);

        // range 3 overflow: 25000-cycle window, edge every 2 cycles
        tick_gap = 25; sig_mode = 1; range_sel = 2'd3;
        repeat (51000) @(negedge clk);
        check("R7", "overflow display", bcd2int(disp_bcd), 9999);
        check("R7", "overflow flag latched", int'(disp_ovf), 1);
        check("R8", "range3 dp", int'(dp_sel), 4'b0010);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule